// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Aggregator

This block gathers level-sensitive interrupt requests into two CPU interrupt lines. Requests arrive in three 8-bit groups: a primary group A, a primary group B and a secondary group. Each primary group has a status view and an enable mask. The CPU line for a group is raised whenever any status bit is set whose enable bit is also set.

The secondary group has one status view and two independent enable masks. When a request passes the first mask, it folds into a fixed bit of primary group A. When a request passes the second mask, it folds into a fixed bit of primary group B. Software must enable that fixed bit in the primary mask as well, or the folded request stops there.

Two timer lines are caught by edge-triggered latches. Each latch drives its own output. Software clears a latch by writing ones to a bit-mapped clear register. All registers are reached over a simple 32-bit register port. Every access completes in the cycle it is presented, so the port has no back-pressure and no handshake. Read data is combinational from the addressed register while `reg_en` is high.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, all four enable masks read 0, both timer latches are clear, and `cpu_irq` and `tmr_irq` are 0.
- R2: `cpu_irq[0]` is high exactly when (group A status AND group A mask) is non-zero. The request inputs are sampled by one register, so a change on an input reaches the output after one rising clock edge.
- R3: `cpu_irq[1]` follows the same rule as R2, using group B status and group B mask.
- R4: A write to any mask register stores `wdata[7:0]`, and a read returns that value. Writing 0 to a mask removes that group's contribution to the outputs.
- R5: The status registers show the sampled request inputs. Writes to a status register are ignored.
- R6: If (secondary status AND secondary mask 0) is non-zero, group A status bit 7 reads 1. That bit raises `cpu_irq[0]` only when group A mask bit 7 is set.
- R7: If (secondary status AND secondary mask 1) is non-zero, group B status bit 3 reads 1. That bit raises `cpu_irq[1]` only when group B mask bit 3 is set.
- R8: A timer latch sets on a rising edge of its timer input, after two clock edges (one edge to sample, one edge to latch). It stays set while the input stays high, and it drives `tmr_irq[i]`.
- R9: A write to the timer-clear register clears timer latch 0 when `wdata` bit 0 is 1, and clears timer latch 1 when `wdata` bit 1 is 1. A write of 0x03 clears both latches. A read of the timer-clear register returns the latch states in bits [1:0].
- R10: If a timer rising edge and a clear of the same latch fall in the same cycle, the latch ends up set.
- R11: The register word addresses are as follows: 0 group A status, 1 group A mask, 2 group B status, 3 group B mask, 4 secondary status, 5 secondary mask 0, 6 secondary mask 1, 7 timer clear. Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when `reg_en` is low |
| grpa_req | input | 8 | Group A level requests |
| grpb_req | input | 8 | Group B level requests |
| sec_req | input | 8 | Secondary group level requests |
| tmr_in | input | 2 | Timer outputs, edge-detected |
| cpu_irq | output | 2 | CPU interrupt lines (0 from group A, 1 from group B) |
| tmr_irq | output | 2 | Timer latch states |

## Verification
Two functions can act in the same cycle: the rising-edge set of a timer latch and a software clear of that latch. The bench raises a timer input, waits one edge for the sampled edge to register, and then places the clear write in the very next cycle. The latch must read set afterwards. In a second case, a folded secondary request and a direct request drive the same primary bit, and the bench checks that masking either one alone changes only the path it gates.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int GRP_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int TMR_N  = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFF_A_STAT   = 3'd0,
    OFF_A_MASK   = 3'd1,
    OFF_B_STAT   = 3'd2,
    OFF_B_MASK   = 3'd3,
    OFF_SEC_STAT = 3'd4,
    OFF_SEC_MSK0 = 3'd5,
    OFF_SEC_MSK1 = 3'd6,
    OFF_TMR_CLR  = 3'd7
  } reg_off_e;
endpackage

// File: rtl/cic_group.sv
module cic_group #(
  parameter int W        = 8,
  parameter int CASC_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         casc_in,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         pend_any
);
  logic [W-1:0] req_q;
  logic [W-1:0] casc_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      mask  <= '0;
    end else begin
      req_q <= req;
      if (mask_we) mask <= mask_wdata;
    end
  end

  always_comb begin
    casc_vec = '0;
    casc_vec[CASC_BIT] = casc_in;
  end

  assign status   = req_q | casc_vec;
  assign pend_any = |(status & mask);

  // R4
  mask_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask == $past(mask_wdata));

  // R2
  no_pend_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !pend_any);
endmodule

// File: rtl/cic_sec_stage.sv
module cic_sec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [1:0]   mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask0,
  output logic [W-1:0] mask1,
  output logic [1:0]   hit
);
  logic [W-1:0] req_q;
  logic [W-1:0] msk [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  for (genvar m = 0; m < 2; m++) begin : g_msk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          msk[m] <= '0;
      else if (mask_we[m]) msk[m] <= mask_wdata;
    end
    assign hit[m] = |(req_q & msk[m]);

    // R6 R7
    sec_mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk[m] == '0) |-> !hit[m]);
  end

  assign status = req_q;
  assign mask0  = msk[0];
  assign mask1  = msk[1];
endmodule

// File: rtl/cic_timer_latch.sv
module cic_timer_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_in,
  input  logic clr,
  output logic latch
);
  logic s_cur, s_prev, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cur  <= 1'b0;
      s_prev <= 1'b0;
      latch  <= 1'b0;
    end else begin
      s_cur  <= tmr_in;
      s_prev <= s_cur;
      if (rise)     latch <= 1'b1;
      else if (clr) latch <= 1'b0;
    end
  end

  assign rise = s_cur & ~s_prev;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && clr) |=> latch);

  // R9
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !latch);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !clr) |=> latch);
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import cic_pkg::*;
#(
  parameter int GW       = GRP_W,
  parameter int NT       = TMR_N,
  parameter int A_CASC   = 7,
  parameter int B_CASC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [GW-1:0]     grpa_req,
  input  logic [GW-1:0]     grpb_req,
  input  logic [GW-1:0]     sec_req,
  input  logic [NT-1:0]     tmr_in,
  output logic [1:0]        cpu_irq,
  output logic [NT-1:0]     tmr_irq
);
  localparam int PAD = DATA_W - GW;
  localparam int TPAD = DATA_W - NT;

  logic          wr_hit;
  logic          a_we, b_we;
  logic [1:0]    sec_we;
  logic [NT-1:0] tmr_clr;
  logic [GW-1:0] a_stat, a_mask, b_stat, b_mask;
  logic [GW-1:0] s_stat, s_mask0, s_mask1;
  logic [1:0]    s_hit;
  reg_off_e      off;

  assign off    = reg_off_e'(reg_addr);
  assign wr_hit = reg_en & reg_wr;
  assign a_we   = wr_hit && (off == OFF_A_MASK);
  assign b_we   = wr_hit && (off == OFF_B_MASK);
  assign sec_we = {wr_hit && (off == OFF_SEC_MSK1), wr_hit && (off == OFF_SEC_MSK0)};
  assign tmr_clr = (wr_hit && (off == OFF_TMR_CLR)) ? reg_wdata[NT-1:0] : '0;

  cic_sec_stage #(.W(GW)) u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (sec_req),
    .mask_we    (sec_we),
    .mask_wdata (reg_wdata[GW-1:0]),
    .status     (s_stat),
    .mask0      (s_mask0),
    .mask1      (s_mask1),
    .hit        (s_hit)
  );

  cic_group #(.W(GW), .CASC_BIT(A_CASC)) u_grpa (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (grpa_req),
    .casc_in    (s_hit[0]),
    .mask_we    (a_we),
    .mask_wdata (reg_wdata[GW-1:0]),
    .status     (a_stat),
    .mask       (a_mask),
    .pend_any   (cpu_irq[0])
  );

  cic_group #(.W(GW), .CASC_BIT(B_CASC)) u_grpb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (grpb_req),
    .casc_in    (s_hit[1]),
    .mask_we    (b_we),
    .mask_wdata (reg_wdata[GW-1:0]),
    .status     (b_stat),
    .mask       (b_mask),
    .pend_any   (cpu_irq[1])
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    cic_timer_latch u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .tmr_in (tmr_in[t]),
      .clr    (tmr_clr[t]),
      .latch  (tmr_irq[t])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en) begin
      case (off)
        OFF_A_STAT:   reg_rdata = {{PAD{1'b0}}, a_stat};
        OFF_A_MASK:   reg_rdata = {{PAD{1'b0}}, a_mask};
        OFF_B_STAT:   reg_rdata = {{PAD{1'b0}}, b_stat};
        OFF_B_MASK:   reg_rdata = {{PAD{1'b0}}, b_mask};
        OFF_SEC_STAT: reg_rdata = {{PAD{1'b0}}, s_stat};
        OFF_SEC_MSK0: reg_rdata = {{PAD{1'b0}}, s_mask0};
        OFF_SEC_MSK1: reg_rdata = {{PAD{1'b0}}, s_mask1};
        OFF_TMR_CLR:  reg_rdata = {{TPAD{1'b0}}, tmr_irq};
        default:      reg_rdata = '0;
      endcase
    end
  end

  // R6
  casc_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit[0] && a_mask[A_CASC]) |-> cpu_irq[0]);

  // R7
  casc_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit[1] && b_mask[B_CASC]) |-> cpu_irq[1]);

  // R1
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mask == '0 && b_mask == '0) |-> (cpu_irq == 2'b00));
endmodule

// File: tb/casc_irq_ctrl_test.sv
module casc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  grpa_req = '0, grpb_req = '0, sec_req = '0;
  logic [1:0]  tmr_in = '0;
  logic [1:0]  cpu_irq, tmr_irq;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  casc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grpa_req(grpa_req), .grpb_req(grpb_req), .sec_req(sec_req),
    .tmr_in(tmr_in), .cpu_irq(cpu_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 1; a < 7; a++) begin
      if (a == 1 || a == 3 || a == 5 || a == 6) begin
        rd(3'(a), rv); check("R1 mask zero after reset", rv, 32'h0);
      end
    end
    check("R1 cpu_irq after reset", {30'b0, cpu_irq}, 32'h0);
    check("R1 tmr_irq after reset", {30'b0, tmr_irq}, 32'h0);
  endtask

  task automatic t_grpa();
    wr(3'd1, 32'hFFFF_FF05);
    rd(3'd1, rv); check("R4 group A mask readback", rv, 32'h05);
    grpa_req = 8'h02; step();
    check("R2 unmasked request", {30'b0, cpu_irq}, 32'h0);
    grpa_req = 8'h04; step();
    check("R2 masked request raises line 0", {30'b0, cpu_irq}, 32'h1);
    rd(3'd0, rv); check("R5 group A status live", rv, 32'h04);
    wr(3'd0, 32'hFF);
    rd(3'd0, rv); check("R5 status write ignored", rv, 32'h04);
    wr(3'd1, 32'h0);
    check("R4 zero mask drops line 0", {30'b0, cpu_irq}, 32'h0);
    grpa_req = 8'h00; step();
  endtask

  task automatic t_grpb();
    wr(3'd3, 32'h81);
    grpb_req = 8'h80; step();
    check("R3 line 1 raised", {30'b0, cpu_irq}, 32'h2);
    rd(3'd2, rv); check("R3 R11 group B status at word 2", rv, 32'h80);
    grpb_req = 8'h00; step();
    check("R3 line 1 drops with request", {30'b0, cpu_irq}, 32'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_sec0();
    wr(3'd5, 32'h10);
    sec_req = 8'h30; step();
    rd(3'd4, rv); check("R11 secondary status at word 4", rv, 32'h30);
    check("R6 folded bit needs primary enable", {30'b0, cpu_irq}, 32'h0);
    rd(3'd0, rv); check("R6 group A bit 7 shows fold", rv, 32'h80);
    wr(3'd1, 32'h80);
    check("R6 line 0 raised by fold", {30'b0, cpu_irq}, 32'h1);
    wr(3'd5, 32'h0);
    check("R6 secondary mask 0 gates fold", {30'b0, cpu_irq}, 32'h0);
    grpa_req = 8'h80; step();
    check("R6 direct request on bit 7 still counts", {30'b0, cpu_irq}, 32'h1);
    grpa_req = 8'h00; sec_req = 8'h00; step();
    wr(3'd1, 32'h0);
  endtask

  task automatic t_sec1();
    wr(3'd6, 32'h01);
    wr(3'd5, 32'h10);
    sec_req = 8'h01; step();
    rd(3'd2, rv); check("R7 group B bit 3 shows fold", rv, 32'h08);
    rd(3'd0, rv); check("R7 no fold into group A", rv, 32'h00);
    wr(3'd3, 32'h08);
    check("R7 line 1 raised by fold", {30'b0, cpu_irq}, 32'h2);
    rd(3'd6, rv); check("R4 secondary mask 1 readback", rv, 32'h01);
    sec_req = 8'h00; step();
    check("R7 fold clears with request", {30'b0, cpu_irq}, 32'h0);
    wr(3'd3, 32'h0); wr(3'd5, 32'h0); wr(3'd6, 32'h0);
  endtask

  task automatic t_timer();
    tmr_in = 2'b01; step();
    check("R8 not yet latched after one edge", {30'b0, tmr_irq}, 32'h0);
    step();
    check("R8 latch 0 set", {30'b0, tmr_irq}, 32'h1);
    rd(3'd7, rv); check("R9 latch read at word 7", rv, 32'h1);
    wr(3'd7, 32'h2);
    check("R9 bit 1 leaves latch 0", {30'b0, tmr_irq}, 32'h1);
    wr(3'd7, 32'h1);
    check("R9 bit 0 clears latch 0 (level held)", {30'b0, tmr_irq}, 32'h0);
    tmr_in = 2'b00; step();
    tmr_in = 2'b11; step(); step();
    check("R8 both latches set", {30'b0, tmr_irq}, 32'h3);
    wr(3'd7, 32'h3);
    check("R9 0x03 clears both", {30'b0, tmr_irq}, 32'h0);
    tmr_in = 2'b00; step(); step();
  endtask

  task automatic t_collide();
    tmr_in = 2'b10; step();
    wr(3'd7, 32'h3);
    check("R10 set beats same-cycle clear", {30'b0, tmr_irq}, 32'h2);
    wr(3'd7, 32'h2);
    check("R10 later clear works", {30'b0, tmr_irq}, 32'h0);
    tmr_in = 2'b00; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_grpa();
    t_grpb();
    t_sec0();
    t_sec1();
    t_timer();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule